// File: doc/BRIEF.md
# Four-Channel Compare-Match Timer

This block is a 16-bit up-counter shared by four compare channels. Each channel owns a compare register and one output pin. A control register chooses what advances the counter. The choices are the system clock divided by 1, 2, 4, 8 or 32, rising edges on an external clock pin, or a pulse stream from a separate fast oscillator. The same register also holds a per-channel initial output level and a switch that makes compare channel A restart the counter from zero.

Software programs the compare values, the levels and the count source through a simple write/read register port, then sets the run bit. In toggle operation, each output starts at its programmed level and inverts on every compare match of its channel. Each match also latches a sticky flag. In PWM operation, each output shows its level bit while the counter is below the channel's compare value and the inverse level from there on. Channel A with clear-on-match sets the period. Stopping the counter returns every output to its programmed level.

Top module: `cmt_top`

## Requirements
- R1: After reset, the control register, the mode register, the match flags, the counter and all compare registers read zero, and all four outputs are low.
- R2: The count-source field is control bits [6:4]. Codes 000, 001, 010, 011 and 100 advance the counter once every 1, 2, 4, 8 and 32 clock cycles of running. The divider restarts from zero each time the run bit goes from 0 to 1.
- R3: With code 101, the external clock pin passes through a two-flop synchronizer and an edge detector. The counter advances exactly once per rising edge on that pin.
- R4: With code 111, the counter advances once for each cycle in which the fast-oscillator pulse input is high. Code 110 is reserved, and the counter holds.
- R5: With the clear bit (control bit 7) at 0, the counter is free-running and wraps from 0xFFFF to 0x0000.
- R6: With the clear bit at 1, a count tick that finds the counter equal to compare A loads 0 in place of incrementing.
- R7: A compare match on channel i is a count tick that finds the counter equal to compare register i. In toggle operation the match inverts output i, and it always sets match flag i. Writing the flag register ANDs the flags with data bits [3:0]: a 0 clears a flag and a 1 leaves it unchanged.
- R8: While the run bit is 0, output i equals level bit i (control bit i). A new level written while the counter is stopped appears on the outputs on the next cycle.
- R9: With the PWM bit set (mode bit 1) and the counter running, output i equals level bit i while the counter is below compare register i, and the inverse of that bit otherwise.
- R10: Register map, 3-bit address: 0 control, 1 mode (bit 0 run, bit 1 PWM), 2 match flags, 3 counter, 4 to 7 compare A to D. A write to address 3 loads the counter and takes priority over counting. A stopped counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data for rd_addr |
| ext_clk | input | 1 | External count clock, asynchronous |
| fast_tick | input | 1 | Fast-oscillator count pulse, one cycle per count |
| tmr_out | output | 4 | Compare outputs, channel A at bit 0 |
| match_flag | output | 4 | Sticky compare-match flags, channel A at bit 0 |

## Verification
A wrong divider phase or a wrong source decode shows as a counter value off by one or more when it is read a known number of cycles after start. A divide-by-32 fault therefore needs at least 32 cycles to appear. A broken clear-on-A path or a broken wrap shows one tick after the counter reaches compare A or 0xFFFF: the counter reads a value other than zero, and the output toggles at the wrong time. Flag or output state that fails to return to the programmed level is visible on the ports one cycle after the stop write.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  localparam int SRC_W = 3;
  localparam int PRE_W = 5;

  typedef enum logic [SRC_W-1:0] {
    SRC_DIV1  = 3'd0,
    SRC_DIV2  = 3'd1,
    SRC_DIV4  = 3'd2,
    SRC_DIV8  = 3'd3,
    SRC_DIV32 = 3'd4,
    SRC_EXT   = 3'd5,
    SRC_RSVD  = 3'd6,
    SRC_FAST  = 3'd7
  } src_e;

  // Decide whether the selected count source fires this cycle.
  function automatic logic src_fires(input logic [SRC_W-1:0] src,
                                     input logic [PRE_W-1:0] pre,
                                     input logic ext_rise,
                                     input logic fast);
    logic r;
    case (src_e'(src))
      SRC_DIV1:  r = 1'b1;
      SRC_DIV2:  r = pre[0];
      SRC_DIV4:  r = &pre[1:0];
      SRC_DIV8:  r = &pre[2:0];
      SRC_DIV32: r = &pre[4:0];
      SRC_EXT:   r = ext_rise;
      SRC_FAST:  r = fast;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cmt_prescale.sv
module cmt_prescale
  import cmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SRC_W-1:0] src,
  input  logic             ext_clk,
  input  logic             fast_tick,
  output logic             tick,
  output logic             ext_rise
);

  logic [2:0]       sync_q;
  logic [PRE_W-1:0] pre_q;

  // Two synchronizer stages plus one history stage for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ext_clk};
  end

  assign ext_rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (!run) pre_q <= '0;
    else          pre_q <= pre_q + 1'b1;
  end

  assign tick = run & src_fires(src, pre_q, ext_rise, fast_tick);

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr_on_a,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt
);

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] a,
                                                  input logic clr);
    if (clr && (c == a)) return '0;
    return c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (ld)    cnt <= ld_val;
    else if (tick)  cnt <= next_count(cnt, cmp_a, clr_on_a);
  end

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pwm,
  input  logic             lvl,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  output logic             match_ev,
  output logic             pin
);

  logic tog_q;
  logic below;

  assign match_ev = tick && (cnt == cmp);
  assign below    = cnt < cmp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tog_q <= 1'b0;
    else if (!run)     tog_q <= lvl;
    else if (match_ev) tog_q <= ~tog_q;
  end

  always_comb begin
    if (!run)     pin = lvl;
    else if (pwm) pin = below ? lvl : ~lvl;
    else          pin = tog_q;
  end

endmodule

// File: rtl/cmt_top.sv
module cmt_top
  import cmt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NCH    = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              ext_clk,
  input  logic              fast_tick,
  output logic [NCH-1:0]    tmr_out,
  output logic [NCH-1:0]    match_flag
);

  localparam int SRC_LSB  = NCH;
  localparam int CLR_BIT  = NCH + SRC_W;
  localparam int A_CTRL   = 0;
  localparam int A_MODE   = 1;
  localparam int A_FLAG   = 2;
  localparam int A_CNT    = 3;
  localparam int CMP_BASE = 4;

  logic [NCH-1:0]   lvl_q;
  logic [SRC_W-1:0] src_q;
  logic             clr_q;
  logic             run_q;
  logic             pwm_q;
  logic [NCH-1:0]   flags_q;
  logic [CNT_W-1:0] cmp_q [NCH];
  logic [CNT_W-1:0] cnt;
  logic             tick;
  logic             ext_rise;
  logic [NCH-1:0]   match_ev;

  logic ctrl_wr, mode_wr, flag_wr, cnt_ld;
  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(A_CTRL));
  assign mode_wr = wr_en && (wr_addr == ADDR_W'(A_MODE));
  assign flag_wr = wr_en && (wr_addr == ADDR_W'(A_FLAG));
  assign cnt_ld  = wr_en && (wr_addr == ADDR_W'(A_CNT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      src_q <= '0;
      clr_q <= 1'b0;
    end else if (ctrl_wr) begin
      lvl_q <= wr_data[NCH-1:0];
      src_q <= wr_data[SRC_LSB +: SRC_W];
      clr_q <= wr_data[CLR_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pwm_q <= 1'b0;
    end else if (mode_wr) begin
      run_q <= wr_data[0];
      pwm_q <= wr_data[1];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cmp_q[i] <= '0;
      else if (wr_en && (wr_addr == ADDR_W'(CMP_BASE + i)))
        cmp_q[i] <= wr_data;
    end
  end

  cmt_prescale u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_q),
    .src       (src_q),
    .ext_clk   (ext_clk),
    .fast_tick (fast_tick),
    .tick      (tick),
    .ext_rise  (ext_rise)
  );

  cmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .clr_on_a (clr_q),
    .cmp_a    (cmp_q[0]),
    .ld       (cnt_ld),
    .ld_val   (wr_data),
    .cnt      (cnt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cmt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_q),
      .pwm      (pwm_q),
      .lvl      (lvl_q[i]),
      .tick     (tick),
      .cnt      (cnt),
      .cmp      (cmp_q[i]),
      .match_ev (match_ev[i]),
      .pin      (tmr_out[i])
    );
  end

  // A new match wins over a clearing write in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags_q <= '0;
    else if (flag_wr) flags_q <= (flags_q & wr_data[NCH-1:0]) | match_ev;
    else              flags_q <= flags_q | match_ev;
  end

  assign match_flag = flags_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(A_CTRL): begin
        rd_data[NCH-1:0]          = lvl_q;
        rd_data[SRC_LSB +: SRC_W] = src_q;
        rd_data[CLR_BIT]          = clr_q;
      end
      ADDR_W'(A_MODE): rd_data[1:0]     = {pwm_q, run_q};
      ADDR_W'(A_FLAG): rd_data[NCH-1:0] = flags_q;
      ADDR_W'(A_CNT):  rd_data          = cnt;
      default: begin
        for (int i = 0; i < NCH; i++)
          if (rd_addr == ADDR_W'(CMP_BASE + i)) rd_data = cmp_q[i];
      end
    endcase
  end

endmodule

// File: rtl/cmt_checker.sv
module cmt_checker
  import cmt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCH   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             ext_rise,
  input logic [SRC_W-1:0] src,
  input logic             run,
  input logic             pwm,
  input logic             clr_on_a,
  input logic             cnt_ld,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp_a,
  input logic [NCH-1:0]   lvl,
  input logic [NCH-1:0]   pins,
  input logic [NCH-1:0]   flags,
  input logic [NCH-1:0]   match_ev,
  input logic             flag_wr,
  input logic [NCH-1:0]   flag_wdata
);

  logic [CNT_W-1:0] cnt_inc;
  assign cnt_inc = cnt + 1'b1;

  // R10: no tick and no load leaves the counter alone
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_ld) |=> $stable(cnt));

  // R5: ordinary tick increments with wrap
  p_increment_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_ld && !(clr_on_a && cnt == cmp_a)) |=> (cnt == $past(cnt_inc)));

  // R6: clear on compare A
  p_clear_on_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_ld && clr_on_a && cnt == cmp_a) |=> (cnt == '0));

  // R4: reserved source code never ticks
  p_reserved_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src == 3'b110) |-> !tick);

  // R3: one pulse per external edge
  p_ext_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise);

  // R8: stopped outputs follow level bits
  p_stop_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pins == lvl));

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    // R7: a match sets its flag
    p_match_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      match_ev[i] |=> flags[i]);

    // R7: a set flag survives unless written with 0
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !(flag_wr && !flag_wdata[i])) |=> flags[i]);

    // R7: in toggle operation a match inverts the pin
    p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (match_ev[i] && run && !pwm && !cnt_ld && $stable(run)) |=> (run ? pins[i] != $past(pins[i]) : 1'b1));
  end

endmodule

bind cmt_top cmt_checker #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .ext_rise   (ext_rise),
  .src        (src_q),
  .run        (run_q),
  .pwm        (pwm_q),
  .clr_on_a   (clr_q),
  .cnt_ld     (cnt_ld),
  .cnt        (cnt),
  .cmp_a      (cmp_q[0]),
  .lvl        (lvl_q),
  .pins       (tmr_out),
  .flags      (flags_q),
  .match_ev   (match_ev),
  .flag_wr    (flag_wr),
  .flag_wdata (wr_data[NCH-1:0])
);

// File: tb/cmt_top_tb.sv
`timescale 1ns/100ps
module cmt_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        ext_clk = 1'b0;
  logic        fast_tick = 1'b0;
  logic [3:0]  tmr_out;
  logic [3:0]  match_flag;

  always #2 clk = ~clk;

  cmt_top dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .ext_clk    (ext_clk),
    .fast_tick  (fast_tick),
    .tmr_out    (tmr_out),
    .match_flag (match_flag)
  );

  typedef struct {
    int          kind;   // 0 register read, 1 outputs, 2 flags
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  event  sample_ev;
  int    checks = 0;
  int    failures = 0;
  bit    finished = 1'b0;

  // Monitor: pops expected items and compares them with the ports.
  initial begin
    forever begin
      @(sample_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = q.pop_front();
        case (it.kind)
          0:       act = rd_data;
          1:       act = {12'b0, tmr_out};
          default: act = {12'b0, match_flag};
        endcase
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic push(input int kind, input logic [15:0] exp, input string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
    #0.1;
    -> sample_ev;
    #0.2;
  endtask

  task automatic exp_reg(input logic [2:0] a, input logic [15:0] exp, input string req);
    rd_addr = a;
    push(0, exp, req);
  endtask

  task automatic exp_out(input logic [3:0] exp, input string req);
    push(1, {12'b0, exp}, req);
  endtask

  task automatic exp_flag(input logic [3:0] exp, input string req);
    push(2, {12'b0, exp}, req);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stop_clear();
    wr(3'd1, 16'h0000);
    wr(3'd3, 16'h0000);
  endtask

  // Watchdog
  initial begin
    #(4 * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1: reset state
    exp_reg(3'd0, 16'h0000, "R1 control");
    exp_reg(3'd1, 16'h0000, "R1 mode");
    exp_reg(3'd3, 16'h0000, "R1 counter");
    exp_reg(3'd6, 16'h0000, "R1 compare C");
    exp_out(4'h0, "R1 outputs");
    exp_flag(4'h0, "R1 flags");

    // R2: divided sources
    wr(3'd4, 16'hFFFF); wr(3'd5, 16'hFFFF); wr(3'd6, 16'hFFFF); wr(3'd7, 16'hFFFF);
    wr(3'd0, 16'h0000); wr(3'd1, 16'h0001); cyc(10);
    exp_reg(3'd3, 16'd10, "R2 div1");
    stop_clear();
    wr(3'd0, 16'h0010); wr(3'd1, 16'h0001); cyc(10);
    exp_reg(3'd3, 16'd5, "R2 div2");
    stop_clear();
    wr(3'd0, 16'h0020); wr(3'd1, 16'h0001); cyc(20);
    exp_reg(3'd3, 16'd5, "R2 div4");
    stop_clear();
    wr(3'd0, 16'h0030); wr(3'd1, 16'h0001); cyc(40);
    exp_reg(3'd3, 16'd5, "R2 div8");
    stop_clear();
    wr(3'd0, 16'h0040); wr(3'd1, 16'h0001); cyc(64);
    exp_reg(3'd3, 16'd2, "R2 div32");
    stop_clear();

    // R4: reserved code holds, fast pulses count
    wr(3'd0, 16'h0060); wr(3'd1, 16'h0001); cyc(20);
    exp_reg(3'd3, 16'd0, "R4 reserved");
    stop_clear();
    wr(3'd0, 16'h0070); wr(3'd1, 16'h0001);
    for (int k = 0; k < 3; k++) begin
      fast_tick = 1'b1; cyc(1); fast_tick = 1'b0; cyc(2);
    end
    exp_reg(3'd3, 16'd3, "R4 fast");
    stop_clear();

    // R3: external edges
    wr(3'd0, 16'h0050); wr(3'd1, 16'h0001);
    for (int k = 0; k < 4; k++) begin
      ext_clk = 1'b1; cyc(3); ext_clk = 1'b0; cyc(3);
    end
    cyc(4);
    exp_reg(3'd3, 16'd4, "R3 external");
    stop_clear();

    // R5: wrap, compare values zero so all channels match at 0
    wr(3'd4, 16'h0000); wr(3'd5, 16'h0000); wr(3'd6, 16'h0000); wr(3'd7, 16'h0000);
    wr(3'd0, 16'h0000); wr(3'd3, 16'hFFFE); wr(3'd1, 16'h0001); cyc(2);
    exp_reg(3'd3, 16'h0000, "R5 wrap");
    cyc(1);
    exp_reg(3'd3, 16'h0001, "R5 after wrap");
    exp_flag(4'hF, "R7 flags set by match");
    exp_out(4'hF, "R7 outputs toggled");

    // R8: stop forces levels, level writes apply at once
    wr(3'd1, 16'h0000);
    exp_out(4'h0, "R8 stop level");
    wr(3'd0, 16'h000A);
    exp_out(4'hA, "R8 new level");

    // R10: load and hold while stopped
    wr(3'd3, 16'h1234); cyc(5);
    exp_reg(3'd3, 16'h1234, "R10 hold stopped");

    // R7: flag clear semantics
    wr(3'd2, 16'h0005);
    exp_flag(4'h5, "R7 partial clear");
    wr(3'd2, 16'h0000);
    exp_flag(4'h0, "R7 clear");
    wr(3'd2, 16'h000F);
    exp_flag(4'h0, "R7 write one no effect");

    // R7: toggle on compare A
    wr(3'd0, 16'h0000); wr(3'd3, 16'h0000);
    wr(3'd4, 16'd5); wr(3'd5, 16'hFFFF); wr(3'd6, 16'hFFFF); wr(3'd7, 16'hFFFF);
    wr(3'd1, 16'h0001); cyc(5);
    exp_out(4'h0, "R7 before match");
    exp_flag(4'h0, "R7 no flag before match");
    cyc(1);
    exp_out(4'h1, "R7 toggle on match");
    exp_flag(4'h1, "R7 flag on match");

    // R6: clear on compare A
    stop_clear();
    wr(3'd4, 16'd3); wr(3'd0, 16'h0080); wr(3'd2, 16'h0000);
    wr(3'd1, 16'h0001); cyc(4);
    exp_reg(3'd3, 16'd0, "R6 cleared");
    exp_out(4'h1, "R6 toggle A");
    cyc(3);
    exp_reg(3'd3, 16'd3, "R6 reaches A");
    cyc(1);
    exp_reg(3'd3, 16'd0, "R6 cleared again");
    exp_out(4'h0, "R6 toggle A back");

    // R9: PWM
    stop_clear();
    wr(3'd0, 16'h0082); wr(3'd4, 16'd6); wr(3'd5, 16'd3);
    exp_reg(3'd5, 16'd3, "R10 compare readback");
    wr(3'd1, 16'h0003); cyc(2);
    exp_out(4'b0010, "R9 B below compare");
    cyc(2);
    exp_out(4'b0000, "R9 B past compare");
    cyc(2);
    exp_out(4'b0001, "R9 A at compare");
    cyc(1);
    exp_reg(3'd3, 16'd0, "R9 period restart");
    exp_out(4'b0010, "R9 new period");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule